// File: doc/BRIEF.md
# Control Register File with Banked Stack Pointer

This block holds the control state of a small processor core: a status word with a stack-mode bit, a backup status byte, a second-level backup status byte, a condition flag, two banked stack-pointer copies (interrupt and user), two backup program counters and two spare 32-bit words. Software-visible control registers are reached through one register index with a write strobe and a combinational read path. The live general-purpose stack pointer (R15) sits in this block as well, and the core's register file reaches it through a dedicated read/write port.

The stack-mode bit (bit 7 of the status byte) decides which banked copy is live. Flipping that bit with a status write exchanges R15 with the banked copies in one clock. A control-register access to the pointer that is currently live goes to R15 itself. An access to the other pointer goes to its stored copy. When a control-register write and a stack-port write happen in the same cycle, the control-register write wins.

Index map: 0 status word, 1 condition flag, 2 interrupt stack pointer, 3 user stack pointer, 4 and 5 spare words, 6 backup PC, 7 second-level backup status, 8 second-level backup PC. Indices 9 to 15 are unused.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset every register, R15 and the stack-mode bit are zero, and every index reads zero.
- R2: Index 0 reads {16'b0, backup_status & 8'hC1, status & 8'hC0 with bit 0 replaced by the condition flag}. Bits 5:1 and 31:16 always read zero.
- R3: A write to index 0 loads the backup status from data bits 15:8 and the status byte from bits 7:0, and sets the condition flag from bit 0.
- R4: A status write that changes stack mode from 0 to 1 stores the old R15 in the user copy and loads R15 from the interrupt copy.
- R5: A status write that changes stack mode from 1 to 0 stores the old R15 in the interrupt copy and loads R15 from the user copy.
- R6: A status write that leaves stack mode unchanged changes neither R15 nor either banked copy.
- R7: When stack mode is 1, index 2 reads and writes R15 and index 3 uses the stored user copy. When stack mode is 0, index 3 reads and writes R15 and index 2 uses the stored interrupt copy.
- R8: Indices 6 and 8 store all 32 written bits and read back with bit 0 forced to zero.
- R9: Index 7 stores the low 8 data bits and reads back only the bits under mask 8'hC1, zero-extended.
- R10: Index 1 reads the condition flag in bit 0 and zeros elsewhere. A write to it sets the flag from data bit 0 and changes nothing else.
- R11: Indices 4 and 5 are independent plain 32-bit read/write words.
- R12: Indices 9 to 15 read zero, and writes to them change no register.
- R13: The stack port always reads R15. A stack-port write loads R15 on the next clock unless a control-register write happens in the same cycle, in which case the stack-port write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_idx | input | IDX_W | Control-register index for read and write |
| cr_we | input | 1 | Control-register write strobe |
| cr_wr_data | input | DATA_W | Control-register write data |
| cr_rd_data | output | DATA_W | Control-register read data (combinational from cr_idx) |
| sp_we | input | 1 | Stack-pointer port write strobe |
| sp_wr_data | input | DATA_W | Stack-pointer port write data |
| sp_rd_data | output | DATA_W | Current R15 value |
| stack_mode | output | 1 | Current stack-mode bit |

## Verification
Status writes are tried with stack mode rising, falling and staying at 0 or at 1, using distinct values in R15 and both copies. A swap that uses the wrong source or misses a copy therefore shows up as a wrong value at index 2, index 3 or the stack port. Pointer accesses at indices 2 and 3 are repeated in both modes, which separates redirection to R15 from an access to the stored copy. All-ones and alternating patterns written to every index show the read masks and the storage widths, and a sweep of all indices after each phase exposes writes that land on a neighbouring or unused index. Writes made in the same cycle on the stack port and the control-register path check which one wins.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   localparam int unsigned IDX_STATUS = 0;
   localparam int unsigned IDX_COND   = 1;
   localparam int unsigned IDX_ISP    = 2;
   localparam int unsigned IDX_USP    = 3;
   localparam int unsigned IDX_BBPSW  = 7;
   localparam int unsigned NUM_WORDS  = 4;
   localparam logic [7:0]  STAT_RD_MASK  = 8'hC0;
   localparam logic [7:0]  BKUP_RD_MASK  = 8'hC1;
   localparam int unsigned MODE_BIT      = 7;

   function automatic int unsigned word_index(input int unsigned i);
      case (i)
         0:       return 4;
         1:       return 5;
         2:       return 6;
         default: return 8;
      endcase
   endfunction

   function automatic bit word_clr_lsb(input int unsigned i);
      return i >= 2;
   endfunction
endpackage

// File: rtl/ctlreg_word.sv
module ctlreg_word #(
   parameter int unsigned W       = 32,
   parameter bit          CLR_LSB = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata
);
   localparam logic [W-1:0] RD_MASK = CLR_LSB ? ~W'(1) : '1;

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

   generate
      if (CLR_LSB) begin : g_masked
         assign rdata = q & RD_MASK;
         assert_lsb_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> (rdata[W-1:1] == $past(wdata[W-1:1])) && (rdata[0] == 1'b0));
      end else begin : g_plain
         assign rdata = q;
         assert_word_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> rdata == $past(wdata));
      end
   endgenerate
endmodule

// File: rtl/ctlreg_status.sv
module ctlreg_status
   import ctlreg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_status,
   input  logic        wr_cond,
   input  logic        wr_bbpsw,
   input  logic [15:0] wdata,
   output logic [15:0] status_rd,
   output logic [7:0]  bbpsw_rd,
   output logic        cond,
   output logic        mode
);
   logic [7:0] stat_q, bkup_q, bbkup_q;
   logic       cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         bkup_q  <= '0;
         bbkup_q <= '0;
         cond_q  <= 1'b0;
      end else begin
         if (wr_status) begin
            stat_q <= wdata[7:0];
            bkup_q <= wdata[15:8];
         end
         if (wr_bbpsw) bbkup_q <= wdata[7:0];
         if (wr_status || wr_cond) cond_q <= wdata[0];
      end
   end

   assign mode      = stat_q[MODE_BIT];
   assign cond      = cond_q;
   assign status_rd = {bkup_q & BKUP_RD_MASK, (stat_q & STAT_RD_MASK) | {7'b0, cond_q}};
   assign bbpsw_rd  = bbkup_q & BKUP_RD_MASK;

   assert_status_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_status |=> (status_rd[15:8] == ($past(wdata[15:8]) & BKUP_RD_MASK))
                 && (status_rd[7:6] == $past(wdata[7:6])) && (cond == $past(wdata[0])));
   assert_status_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd[5:1] == 5'b0);
   assert_cond_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cond && !wr_status) |=> (cond == $past(wdata[0])) && $stable(mode));
endmodule

// File: rtl/ctlreg_stack.sv
module ctlreg_stack #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mode,
   input  logic         swap_en,
   input  logic         new_mode,
   input  logic         isp_we,
   input  logic         usp_we,
   input  logic         sp_we,
   input  logic [W-1:0] cr_wdata,
   input  logic [W-1:0] sp_wdata,
   output logic [W-1:0] r15,
   output logic [W-1:0] isp_rd,
   output logic [W-1:0] usp_rd
);
   logic [W-1:0] r15_q, isp_q, usp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r15_q <= '0;
         isp_q <= '0;
         usp_q <= '0;
      end else if (swap_en) begin
         if (new_mode) begin
            usp_q <= r15_q;
            r15_q <= isp_q;
         end else begin
            isp_q <= r15_q;
            r15_q <= usp_q;
         end
      end else if (isp_we) begin
         if (mode) r15_q <= cr_wdata;
         else      isp_q <= cr_wdata;
      end else if (usp_we) begin
         if (!mode) r15_q <= cr_wdata;
         else       usp_q <= cr_wdata;
      end else if (sp_we) begin
         r15_q <= sp_wdata;
      end
   end

   assign r15    = r15_q;
   assign isp_rd = mode ? r15_q : isp_q;
   assign usp_rd = mode ? usp_q : r15_q;

   assert_swap_to_sys_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_en && new_mode) |=> (r15 == $past(isp_q)) && (usp_q == $past(r15)));
   assert_swap_to_usr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_en && !new_mode) |=> (r15 == $past(usp_q)) && (isp_q == $past(r15)));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(swap_en || isp_we || usp_we || sp_we) |=> $stable(r15) && $stable(isp_q) && $stable(usp_q));
   assert_live_isp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!swap_en && isp_we && mode) |=> (r15 == $past(cr_wdata)) && $stable(isp_q));
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
   import ctlreg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  cr_idx,
   input  logic              cr_we,
   input  logic [DATA_W-1:0] cr_wr_data,
   output logic [DATA_W-1:0] cr_rd_data,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] sp_wr_data,
   output logic [DATA_W-1:0] sp_rd_data,
   output logic              stack_mode
);
   localparam int unsigned NUM_IDX = 1 << IDX_W;

   if (DATA_W < 16) begin : g_bad_width
      $error("ctlreg_bank: DATA_W must be at least 16");
   end
   if (IDX_W < 4) begin : g_bad_idx
      $error("ctlreg_bank: IDX_W must be at least 4");
   end

   logic              hit_status, hit_cond, hit_isp, hit_usp, hit_bbpsw;
   logic [15:0]       status_rd;
   logic [7:0]        bbpsw_rd;
   logic              cond;
   logic              mode;
   logic [DATA_W-1:0] r15, isp_rd, usp_rd;
   logic [DATA_W-1:0] word_rd [NUM_WORDS];
   logic [NUM_WORDS-1:0] word_hit;
   logic              swap_en;
   logic              known_idx;

   assign hit_status = cr_idx == IDX_W'(IDX_STATUS);
   assign hit_cond   = cr_idx == IDX_W'(IDX_COND);
   assign hit_isp    = cr_idx == IDX_W'(IDX_ISP);
   assign hit_usp    = cr_idx == IDX_W'(IDX_USP);
   assign hit_bbpsw  = cr_idx == IDX_W'(IDX_BBPSW);
   assign swap_en    = cr_we && hit_status && (cr_wr_data[MODE_BIT] != mode);

   ctlreg_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_status (cr_we && hit_status),
      .wr_cond   (cr_we && hit_cond),
      .wr_bbpsw  (cr_we && hit_bbpsw),
      .wdata     (cr_wr_data[15:0]),
      .status_rd (status_rd),
      .bbpsw_rd  (bbpsw_rd),
      .cond      (cond),
      .mode      (mode)
   );

   ctlreg_stack #(.W(DATA_W)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .swap_en  (swap_en),
      .new_mode (cr_wr_data[MODE_BIT]),
      .isp_we   (cr_we && hit_isp),
      .usp_we   (cr_we && hit_usp),
      .sp_we    (sp_we && !cr_we),
      .cr_wdata (cr_wr_data),
      .sp_wdata (sp_wr_data),
      .r15      (r15),
      .isp_rd   (isp_rd),
      .usp_rd   (usp_rd)
   );

   for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
      assign word_hit[gi] = cr_idx == IDX_W'(word_index(gi));
      ctlreg_word #(.W(DATA_W), .CLR_LSB(word_clr_lsb(gi))) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (cr_we && word_hit[gi]),
         .wdata (cr_wr_data),
         .rdata (word_rd[gi])
      );
   end

   assign known_idx = hit_status || hit_cond || hit_isp || hit_usp || hit_bbpsw || (|word_hit);

   always_comb begin
      cr_rd_data = '0;
      if (hit_status) cr_rd_data = DATA_W'(status_rd);
      if (hit_cond)   cr_rd_data = DATA_W'(cond);
      if (hit_isp)    cr_rd_data = isp_rd;
      if (hit_usp)    cr_rd_data = usp_rd;
      if (hit_bbpsw)  cr_rd_data = DATA_W'(bbpsw_rd);
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (word_hit[i]) cr_rd_data = word_rd[i];
      end
   end

   assign sp_rd_data = r15;
   assign stack_mode = mode;

   assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !known_idx |-> cr_rd_data == '0);
   assert_unused_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_we && !known_idx && !sp_we) |=> $stable(sp_rd_data) && $stable(stack_mode));
   assert_bbpsw_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_bbpsw |-> (cr_rd_data & ~DATA_W'(BKUP_RD_MASK)) == '0);
   assert_sp_port_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we && !cr_we) |=> sp_rd_data == $past(sp_wr_data));
   assert_sp_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we && cr_we && !hit_status && !hit_isp && !hit_usp) |=> $stable(sp_rd_data));
   assert_no_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_we && hit_status && (cr_wr_data[MODE_BIT] == mode)) |=> $stable(sp_rd_data));
endmodule

// File: tb/test_ctlreg_bank.sv
`timescale 1ns/1ps
module test_ctlreg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cr_idx = '0;
   logic        cr_we = 1'b0;
   logic [31:0] cr_wr_data = '0;
   logic [31:0] cr_rd_data;
   logic        sp_we = 1'b0;
   logic [31:0] sp_wr_data = '0;
   logic [31:0] sp_rd_data;
   logic        stack_mode;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ctlreg_bank i_ctlreg_bank (
      .clk(clk), .rst_n(rst_n), .cr_idx(cr_idx), .cr_we(cr_we),
      .cr_wr_data(cr_wr_data), .cr_rd_data(cr_rd_data), .sp_we(sp_we),
      .sp_wr_data(sp_wr_data), .sp_rd_data(sp_rd_data), .stack_mode(stack_mode)
   );

   // behavioural reference state
   logic [7:0]  m_stat, m_bkup, m_bbkup;
   bit          m_cond;
   logic [31:0] m_r15, m_isp, m_usp, m_bpc, m_bbpc;
   logic [31:0] m_spare [2];

   task automatic model_reset();
      m_stat = '0; m_bkup = '0; m_bbkup = '0; m_cond = 0;
      m_r15 = '0; m_isp = '0; m_usp = '0; m_bpc = '0; m_bbpc = '0;
      m_spare[0] = '0; m_spare[1] = '0;
   endtask

   function automatic logic [31:0] model_read(input int idx);
      bit md = m_stat[7];
      case (idx)
         0: return {16'b0, m_bkup & 8'hC1, m_stat[7:6], 5'b0, m_cond};
         1: return {31'b0, m_cond};
         2: return md ? m_r15 : m_isp;
         3: return md ? m_usp : m_r15;
         4: return m_spare[0];
         5: return m_spare[1];
         6: return {m_bpc[31:1], 1'b0};
         7: return {24'b0, m_bbkup & 8'hC1};
         8: return {m_bbpc[31:1], 1'b0};
         default: return 32'b0;
      endcase
   endfunction

   task automatic model_update(input bit we, input int idx, input logic [31:0] d,
                               input bit spwe, input logic [31:0] spd);
      bit md = m_stat[7];
      if (we) begin
         case (idx)
            0: begin
               if (d[7] != md) begin
                  if (d[7]) begin m_usp = m_r15; m_r15 = m_isp; end
                  else      begin m_isp = m_r15; m_r15 = m_usp; end
               end
               m_bkup = d[15:8]; m_stat = d[7:0]; m_cond = d[0];
            end
            1: m_cond = d[0];
            2: if (md) m_r15 = d; else m_isp = d;
            3: if (!md) m_r15 = d; else m_usp = d;
            4: m_spare[0] = d;
            5: m_spare[1] = d;
            6: m_bpc = d;
            7: m_bbkup = d[7:0];
            8: m_bbpc = d;
            default: ;
         endcase
      end else if (spwe) begin
         m_r15 = spd;
      end
   endtask

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive, compare current state, update model at the edge
   task automatic cyc(input bit we, input int idx, input logic [31:0] d,
                      input bit spwe, input logic [31:0] spd, input string tag);
      @(negedge clk);
      cr_we = we; cr_idx = 4'(idx); cr_wr_data = d; sp_we = spwe; sp_wr_data = spd;
      #1;
      check(tag, $sformatf("read idx %0d", idx), cr_rd_data, model_read(idx));
      check(tag, "stack port", sp_rd_data, m_r15);
      check(tag, "stack mode", {31'b0, stack_mode}, {31'b0, m_stat[7]});
      @(posedge clk);
      model_update(we, idx, d, spwe, spd);
   endtask

   task automatic wr(input int idx, input logic [31:0] d, input string tag);
      cyc(1, idx, d, 0, '0, tag);
   endtask

   task automatic rd(input int idx, input string tag);
      cyc(0, idx, '0, 0, '0, tag);
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < 16; i++) rd(i, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state at every index
      sweep("R1");

      // R13: stack port writes and reads R15
      cyc(0, 0, '0, 1, 32'hA000_1000, "R13");
      rd(3, "R13");
      // R7: mode 0, index 3 is R15, index 2 is stored copy
      wr(2, 32'h1111_2220, "R7");
      rd(2, "R7"); rd(3, "R7");
      wr(3, 32'h3333_4440, "R7");
      rd(3, "R7"); rd(2, "R7");

      // R2 R3: status write with mode kept at 0, all ones in other fields
      wr(0, 32'hFFFF_FF7F, "R3");
      rd(0, "R2"); rd(1, "R10");
      // R6: R15 and copies unchanged
      rd(2, "R6"); rd(3, "R6");

      // R4: mode 0 -> 1
      wr(0, 32'h0000_0080, "R4");
      rd(0, "R2"); rd(2, "R4"); rd(3, "R4");
      // R7: mode 1 redirection
      wr(2, 32'h5555_6660, "R7");
      rd(2, "R7"); rd(3, "R7");
      wr(3, 32'h7777_8880, "R7");
      rd(3, "R7"); rd(2, "R7");
      // R6: status write keeping mode 1
      wr(0, 32'hAAAA_55C1, "R6");
      rd(2, "R6"); rd(3, "R6"); rd(0, "R2");

      // R5: mode 1 -> 0
      cyc(0, 0, '0, 1, 32'h9999_0004, "R13");
      wr(0, 32'h0000_0041, "R5");
      rd(2, "R5"); rd(3, "R5"); rd(0, "R2");

      // R10: condition flag writes
      wr(1, 32'hFFFF_FFFE, "R10");
      rd(1, "R10"); rd(0, "R10");
      wr(1, 32'h0000_0001, "R10");
      rd(1, "R10"); rd(0, "R10");

      // R11: spare words
      wr(4, 32'hDEAD_BEEF, "R11");
      wr(5, 32'h0123_4567, "R11");
      rd(4, "R11"); rd(5, "R11");
      wr(5, 32'hFEDC_BA98, "R11");
      rd(4, "R11"); rd(5, "R11");

      // R8: backup PCs, odd values
      wr(6, 32'hFFFF_FFFF, "R8");
      wr(8, 32'h8765_4321, "R8");
      rd(6, "R8"); rd(8, "R8");
      // R9: second-level backup status
      wr(7, 32'hFFFF_FFFF, "R9");
      rd(7, "R9");
      wr(7, 32'h0000_003E, "R9");
      rd(7, "R9");

      // R12: writes to unused indices
      for (int i = 9; i < 16; i++) wr(i, 32'hFFFF_FFFF, "R12");
      sweep("R12");

      // R13: collision, control write wins over stack port
      cyc(1, 4, 32'h4444_0000, 1, 32'hBAD0_0000, "R13");
      rd(3, "R13"); rd(4, "R13");
      cyc(1, 3, 32'h2468_ACE0, 1, 32'hBAD0_0001, "R13");
      rd(3, "R13");
      cyc(1, 0, 32'h0000_0080, 1, 32'hBAD0_0002, "R13");
      rd(2, "R13"); rd(3, "R13");
      cyc(0, 0, '0, 1, 32'h1357_9BDF, "R13");
      sweep("R4");

      // R1: reset again in the middle
      @(negedge clk);
      cr_we = 0; sp_we = 0;
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      sweep("R1");

      finish_run();
   end
endmodule